// File: doc/BRIEF.md
# Page Program Engine

This block takes one write command at a time from a serial front end and collects it into a page buffer. The command supplies a start address, followed by a stream of data bytes. When chip select rises exactly on a byte boundary, the engine runs one self-timed programming cycle. During that cycle it drives the loaded bytes onto a write port for the storage array and holds a busy flag high. When the cycle ends, it pulses a request that clears the write-enable latch.

Addresses wrap inside one page. If the host sends more bytes than a page holds, the later bytes replace the earlier ones. The engine drops the command when chip select rises off a byte boundary, when no data byte arrived, or when the write-enable latch was clear at the start of the command. It never writes bytes that fall in the block-protected region. While a cycle is running, the engine ignores every strobe from the front end. The cycle length is a parameter counted in system clocks.

Top module: `page_prog_engine`

## Requirements
- R1: The data bytes of a committed command are written to consecutive addresses, beginning at the command's start address.
- R2: After each data byte, only the low 5 address bits (the offset within the 32-byte page) advance, wrapping from 31 to 0. The upper address bits stay fixed.
- R3: When more than 32 bytes arrive in one command, a later byte at the same page offset replaces the earlier one. Only the last value is written.
- R4: A `cs_rise` with `cs_aligned` low discards the command. Busy does not rise and no byte is written.
- R5: A command that started while `wel_in` was 0 is discarded when chip select rises.
- R6: `bp_level`, sampled on the committing edge, selects the protected region: 0 protects nothing, 1 protects addresses whose two top bits are 11, 2 protects addresses whose top bit is 1, and 3 protects every address. Protected bytes are never written.
- R7: `busy` goes high on the clock after a committing `cs_rise` and stays high for exactly `CYCLE_CLKS` clocks. `wel_clear` is high for one clock, the one right after `busy` falls.
- R8: While `busy` is high, `cmd_start`, `data_strobe` and `cs_rise` have no effect.
- R9: Bytes of the page that the command did not load keep their previous contents.
- R10: `mem_we` is asserted only while `busy` is high.
- R11: An aligned `cs_rise` with no data byte loaded starts no cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Pulse: a write command opens, with its address on `cmd_addr` |
| cmd_addr | input | ADDR_W | Start byte address of the command |
| data_strobe | input | 1 | Pulse: one data byte is present on `data_byte` |
| data_byte | input | DATA_W | Data byte |
| cs_rise | input | 1 | Pulse: chip select rose |
| cs_aligned | input | 1 | Qualifies `cs_rise`: the rise came right after a complete byte |
| wel_in | input | 1 | Current state of the write-enable latch |
| bp_level | input | 2 | Block protection level |
| busy | output | 1 | Programming cycle in progress |
| wel_clear | output | 1 | One-clock request to clear the write-enable latch |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | DATA_W | Array write data |

## Verification
The hardest situation to reach is a complete command that arrives during a running cycle. Such a command carries a valid enable, an aligned rise and real data, so it would commit if the engine were idle. The stimulus issues it right after a commit, while busy is high. The bench then checks three things: the busy window is still exactly one cycle long, no extra write reaches the array, and no second cycle follows. Page wrap-around with overwrite is reached by sending 34 bytes from a page start. Partial-page preservation is checked by overwriting two bytes of a page that was filled earlier.

// File: rtl/ppe_pkg.sv
package ppe_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } ppe_state_t;

  // level 0: none, 1: top quarter, 2: top half, 3: everything
  function automatic logic in_guarded(input logic [1:0] lvl, input logic [1:0] top2);
    logic hit;
    case (lvl)
      2'd0:    hit = 1'b0;
      2'd1:    hit = (top2 == 2'b11);
      2'd2:    hit = top2[1];
      default: hit = 1'b1;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/ppe_page_buf.sv
module ppe_page_buf #(
  parameter int PAGE_BYTES = 32,
  parameter int DATA_W     = 8,
  parameter int OFF_W      = 5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  open_i,
  input  logic [OFF_W-1:0]      start_off_i,
  input  logic                  wr_i,
  input  logic [DATA_W-1:0]     wr_data_i,
  input  logic [OFF_W-1:0]      rd_idx_i,
  output logic [DATA_W-1:0]     rd_data_o,
  output logic [PAGE_BYTES-1:0] loaded_o,
  output logic                  any_o
);

  logic [DATA_W-1:0] store [PAGE_BYTES];
  logic [OFF_W-1:0]  wptr;

  // storage without reset, synchronous read: block RAM friendly
  always_ff @(posedge clk) begin
    if (wr_i) store[wptr] <= wr_data_i;
    rd_data_o <= store[rd_idx_i];
  end

  // write pointer wraps naturally inside the page
  always_ff @(posedge clk) begin
    if (rst) begin
      wptr     <= '0;
      loaded_o <= '0;
    end else if (open_i) begin
      wptr     <= start_off_i;
      loaded_o <= '0;
    end else if (wr_i) begin
      wptr           <= wptr + 1'b1;
      loaded_o[wptr] <= 1'b1;
    end
  end

  assign any_o = |loaded_o;

endmodule

// File: rtl/ppe_timer.sv
module ppe_timer #(
  parameter int CYC   = 36,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             en_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o
);

  always_ff @(posedge clk) begin
    if (rst || clr_i) cnt_o <= '0;
    else if (en_i)    cnt_o <= cnt_o + 1'b1;
  end

  assign last_o = en_i && (cnt_o == CNT_W'(CYC - 1));

endmodule

// File: rtl/ppe_guard.sv
module ppe_guard
  import ppe_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go_i,
  input  logic [1:0]        lvl_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o
);

  logic blocked;
  assign blocked = in_guarded(lvl_i, addr_i[ADDR_W-1 -: 2]);

  always_ff @(posedge clk) begin
    if (rst) mem_we_o <= 1'b0;
    else     mem_we_o <= go_i && !blocked;
    mem_addr_o  <= addr_i;
    mem_wdata_o <= data_i;
  end

endmodule

// File: rtl/page_prog_engine.sv
module page_prog_engine
  import ppe_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 32,
  parameter int CYCLE_CLKS = 250000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_start,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              data_strobe,
  input  logic [DATA_W-1:0] data_byte,
  input  logic              cs_rise,
  input  logic              cs_aligned,
  input  logic              wel_in,
  input  logic [1:0]        bp_level,
  output logic              busy,
  output logic              wel_clear,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);

  localparam int OFF_W = $clog2(PAGE_BYTES);
  localparam int HI_W  = ADDR_W - OFF_W;
  localparam int MIN_C = PAGE_BYTES + 4;
  localparam int CYC   = (CYCLE_CLKS > MIN_C) ? CYCLE_CLKS : MIN_C;
  localparam int CNT_W = $clog2(CYC + 1);

  ppe_state_t      state_q;
  logic [HI_W-1:0] base_q;
  logic            wel_ok_q;
  logic [1:0]      lvl_q;

  logic                  st_open, byte_take, rise_take, commit, in_prog, drain;
  logic [CNT_W-1:0]      cnt;
  logic                  t_last;
  logic [OFF_W-1:0]      rd_idx;
  logic [DATA_W-1:0]     rd_data;
  logic [PAGE_BYTES-1:0] loaded;
  logic                  any_loaded;
  logic                  s1_go;
  logic [OFF_W-1:0]      s1_off;

  always_comb begin
    in_prog   = (state_q == ST_PROG);
    st_open   = cmd_start && !in_prog;
    byte_take = data_strobe && (state_q == ST_LOAD) && !cmd_start;
    rise_take = cs_rise && (state_q == ST_LOAD) && !cmd_start;
    commit    = rise_take && cs_aligned && wel_ok_q && any_loaded;
    drain     = in_prog && (cnt < CNT_W'(PAGE_BYTES));
    rd_idx    = cnt[OFF_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      base_q   <= '0;
      wel_ok_q <= 1'b0;
      lvl_q    <= 2'd0;
    end else if (st_open) begin
      state_q  <= ST_LOAD;
      base_q   <= cmd_addr[ADDR_W-1:OFF_W];
      wel_ok_q <= wel_in;
    end else if (rise_take) begin
      state_q <= commit ? ST_PROG : ST_IDLE;
      if (commit) lvl_q <= bp_level;
    end else if (in_prog && t_last) begin
      state_q <= ST_IDLE;
    end
  end

  ppe_page_buf #(
    .PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W), .OFF_W(OFF_W)
  ) u_buf (
    .clk(clk), .rst(rst),
    .open_i(st_open), .start_off_i(cmd_addr[OFF_W-1:0]),
    .wr_i(byte_take), .wr_data_i(data_byte),
    .rd_idx_i(rd_idx), .rd_data_o(rd_data),
    .loaded_o(loaded), .any_o(any_loaded)
  );

  ppe_timer #(.CYC(CYC), .CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst(rst), .clr_i(commit), .en_i(in_prog),
    .cnt_o(cnt), .last_o(t_last)
  );

  // stage 1: pick the byte slot, read issued to the buffer
  always_ff @(posedge clk) begin
    if (rst) s1_go <= 1'b0;
    else     s1_go <= drain && loaded[rd_idx];
    s1_off <= rd_idx;
  end

  // stage 2: protection gate and registered write port
  ppe_guard #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_grd (
    .clk(clk), .rst(rst),
    .go_i(s1_go), .lvl_i(lvl_q),
    .addr_i({base_q, s1_off}), .data_i(rd_data),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata)
  );

  always_ff @(posedge clk) begin
    if (rst) wel_clear <= 1'b0;
    else     wel_clear <= in_prog && t_last;
  end

  assign busy = in_prog;

endmodule

// File: rtl/ppe_chk.sv
module ppe_chk #(
  parameter int ADDR_W = 12,
  parameter int OFF_W  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              wel_clear,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              cs_rise,
  input logic              cs_aligned
);

  // R10
  we_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy);

  // R7
  clear_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> wel_clear);

  // R7
  clear_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    wel_clear |=> !wel_clear);

  // R4
  misaligned_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (cs_rise && !cs_aligned && !busy) |=> !busy);

  // R2
  same_page_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_we && $past(mem_we)) |->
      (mem_addr[ADDR_W-1:OFF_W] == $past(mem_addr[ADDR_W-1:OFF_W])));

  // R8
  rise_from_cs_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(cs_rise));

endmodule

bind page_prog_engine ppe_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .wel_clear(wel_clear),
  .mem_we(mem_we), .mem_addr(mem_addr),
  .cs_rise(cs_rise), .cs_aligned(cs_aligned)
);

// File: tb/sim_page_prog_engine.sv
module sim_page_prog_engine;

  localparam int CLK_PERIOD = 10;
  localparam int AW    = 12;
  localparam int DW    = 8;
  localparam int PAGE  = 32;
  localparam int CYC   = 48;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_start = 0, data_strobe = 0, cs_rise = 0, cs_aligned = 0, wel_in = 0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] data_byte = '0;
  logic [1:0]    bp_level = 2'd0;
  logic          busy, wel_clear, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;

  int n_chk = 0, n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  page_prog_engine #(.ADDR_W(AW), .DATA_W(DW), .PAGE_BYTES(PAGE), .CYCLE_CLKS(CYC)) u0 (
    .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_addr(cmd_addr),
    .data_strobe(data_strobe), .data_byte(data_byte),
    .cs_rise(cs_rise), .cs_aligned(cs_aligned), .wel_in(wel_in), .bp_level(bp_level),
    .busy(busy), .wel_clear(wel_clear), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  // behavioural reference state
  logic [7:0] exp_mem [DEPTH];
  logic [7:0] shd_mem [DEPTH];
  byte unsigned q[$];
  bit  m_open, m_wel, m_wc;
  int  m_addr, m_left;
  int  run = 0, last_run = 0;
  bit  busy_seen = 0;

  function automatic bit guarded(input int lvl, input int a);
    if (lvl == 0) return 0;
    if (lvl == 1) return a >= (DEPTH * 3) / 4;
    if (lvl == 2) return a >= DEPTH / 2;
    return 1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_open = 0; m_wel = 0; m_wc = 0; m_left = 0; q.delete();
    end else begin
      m_wc = 0;
      if (m_left > 0) begin
        m_left--;
        if (m_left == 0) m_wc = 1;
      end else if (cmd_start) begin
        m_open = 1; m_wel = wel_in; m_addr = int'(cmd_addr); q.delete();
      end else if (data_strobe && m_open) begin
        q.push_back(data_byte);
      end else if (cs_rise && m_open) begin
        m_open = 0;
        if (cs_aligned && m_wel && q.size() > 0) begin
          for (int i = 0; i < q.size(); i++) begin
            int a;
            a = (m_addr / PAGE) * PAGE + ((m_addr + i) % PAGE);
            if (!guarded(int'(bp_level), a)) exp_mem[a] = q[i];
          end
          m_left = CYC;
        end
      end
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      n_chk++;
      if (busy !== (m_left > 0)) begin
        n_err++; $display("FAIL R7 busy actual=%0b expected=%0b", busy, m_left > 0);
      end
      n_chk++;
      if (wel_clear !== m_wc) begin
        n_err++; $display("FAIL R7 wel_clear actual=%0b expected=%0b", wel_clear, m_wc);
      end
      if (mem_we) begin
        n_chk++;
        if (!busy) begin
          n_err++; $display("FAIL R10 mem_we while idle actual=1 expected=0");
        end
        shd_mem[mem_addr] = mem_wdata;
      end
      if (busy) begin run++; busy_seen = 1; end
      else if (run > 0) begin last_run = run; run = 0; end
    end
  end

  task automatic send_write(input int addr, input int n, input int seed,
                            input bit aligned, input bit wel);
    @(negedge clk);
    cmd_start = 1; cmd_addr = AW'(addr); wel_in = wel;
    @(negedge clk);
    cmd_start = 0;
    for (int i = 0; i < n; i++) begin
      data_strobe = 1; data_byte = DW'(seed + i * 37);
      @(negedge clk);
      data_strobe = 0;
    end
    cs_rise = 1; cs_aligned = aligned;
    @(negedge clk);
    cs_rise = 0; cs_aligned = 0;
  endtask

  task automatic wait_idle();
    while (busy || m_left > 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic check_mem(input string tag);
    int bad = 0, first = -1;
    for (int a = 0; a < DEPTH; a++)
      if (shd_mem[a] !== exp_mem[a]) begin bad++; if (first < 0) first = a; end
    n_chk++;
    if (bad != 0) begin
      n_err++;
      $display("FAIL %s array addr=%0h actual=%0h expected=%0h (%0d bad)",
               tag, first, shd_mem[first], exp_mem[first], bad);
    end
  endtask

  task automatic check_run(input string tag);
    n_chk++;
    if (last_run != CYC) begin
      n_err++; $display("FAIL %s busy length actual=%0d expected=%0d", tag, last_run, CYC);
    end
  endtask

  task automatic check_no_busy(input string tag);
    repeat (4) @(negedge clk);
    n_chk++;
    if (busy_seen) begin
      n_err++; $display("FAIL %s busy rose actual=1 expected=0", tag);
    end
  endtask

  bit done = 0;

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_err++; $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < DEPTH; a++) begin exp_mem[a] = 8'h00; shd_mem[a] = 8'h00; end
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // reset state (R7, R10)
    n_chk++;
    if (busy !== 1'b0 || wel_clear !== 1'b0 || mem_we !== 1'b0) begin
      n_err++; $display("FAIL R7 reset outputs actual=%0b%0b%0b expected=000", busy, wel_clear, mem_we);
    end

    // R1: three bytes mid-page
    send_write(12'h123, 3, 8'h11, 1, 1); wait_idle();
    check_mem("R1"); check_run("R7");

    // R2: start at offset 30, wrap to page start
    send_write(12'h05E, 5, 8'h40, 1, 1); wait_idle();
    check_mem("R2");

    // R3: 34 bytes from page start, offsets 0 and 1 replaced
    send_write(12'h200, 34, 8'h07, 1, 1); wait_idle();
    check_mem("R3");

    // R9: two bytes into the filled page, rest preserved
    send_write(12'h202, 2, 8'hA5, 1, 1); wait_idle();
    check_mem("R9");

    // R4: misaligned rise
    busy_seen = 0;
    send_write(12'h300, 3, 8'h5A, 0, 1); check_no_busy("R4"); check_mem("R4");

    // R5: enable latch clear at command start
    busy_seen = 0;
    send_write(12'h340, 4, 8'h33, 1, 0); check_no_busy("R5"); check_mem("R5");

    // R11: aligned rise right after the address, no data
    busy_seen = 0;
    send_write(12'h360, 0, 8'h00, 1, 1); check_no_busy("R11");

    // R6: protection levels
    bp_level = 2'd1;
    send_write(12'hC10, 3, 8'h71, 1, 1); wait_idle();
    send_write(12'hB10, 3, 8'h72, 1, 1); wait_idle();
    check_mem("R6 level1");
    bp_level = 2'd2;
    send_write(12'h820, 3, 8'h81, 1, 1); wait_idle();
    send_write(12'h7E0, 3, 8'h82, 1, 1); wait_idle();
    check_mem("R6 level2");
    bp_level = 2'd3;
    send_write(12'h010, 3, 8'h91, 1, 1); wait_idle();
    check_mem("R6 level3");
    bp_level = 2'd0;

    // R8: a full command issued while busy is ignored
    send_write(12'h400, 2, 8'hC3, 1, 1);
    send_write(12'h500, 3, 8'hD4, 1, 1);
    wait_idle();
    check_mem("R8"); check_run("R8");
    busy_seen = 0;
    check_no_busy("R8");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule